// File: doc/BRIEF.md
# Priority Pool Bus Arbiter

This block decides which of N bus masters owns one slave port. Every master carries a 2-bit pool field that software programs. The field places the master in one of four pools. Pool 3 is for latency-critical traffic, pool 2 for latency-sensitive traffic, pool 1 for bandwidth-sensitive traffic and pool 0 for background transfers. A request in a higher pool always beats any request in a lower pool. Inside pool 3 and pool 0 the masters take turns in a rotating order. Inside pools 2 and 1 the order is fixed. Any spread of masters across the pools is legal, and some pools may stay empty.

A decision is made only on a cycle where the arbitration strobe is high. The surrounding logic raises that strobe when an access ends or when a slot timer expires. The chosen owner appears at the outputs on the next clock and stays there until the next strobe. If no master is requesting at a strobe, the grant stays parked on the last owner. Pool 3 and pool 0 each keep their own rotation pointer. After each grant from its pool, that pointer moves to the index just past the winner.

A two-state machine tracks whether the grant is parked or owned. Its states and transitions are:
- ST_PARK to ST_OWN: strobe with at least one request.
- ST_OWN to ST_PARK: strobe with no request.
- Any other cycle keeps the current state.

Top module: `pp_bus_arbiter`

## Requirements
- R1: After reset `gnt_idx` is 0, `gnt` has only bit 0 set, `gnt_held` is 0, and both rotation pointers are 0.
- R2: `gnt` always has exactly one bit set, and that bit is bit `gnt_idx`.
- R3: The pool of master m is `prio[2m+1:2m]`, where 3 means critical, 2 latency, 1 bandwidth and 0 background. At a strobe with requests, the winner is a requester from the highest pool that has any requester.
- R4: When pool 3 wins, the grant goes to the first pool-3 requester found by searching upward from the pool-3 pointer and wrapping around. The pointer then becomes winner+1, which wraps to 0 after N-1.
- R5: Pool 0 follows the same rotation rule with its own pointer. Grants from other pools leave that pointer unchanged.
- R6: When pool 2 or pool 1 wins, the requester with the lowest index in that pool gets the grant, every time.
- R7: Take a master that keeps requesting in pool 3. It loses at most N-1 consecutive strobes before it is granted.
- R8: While `arb_en` is low, `gnt`, `gnt_idx` and `gnt_held` do not change.
- R9: At a strobe with no requests, `gnt_idx` keeps its value and `gnt_held` goes to 0. At a strobe with a request, `gnt_held` goes to 1.
- R10: The result of a strobe appears on the outputs at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_en | input | 1 | Arbitration strobe |
| req | input | NUM_MST | Request from each master |
| prio | input | 2*NUM_MST | Pool field of each master; master m uses bits [2m+1:2m] |
| gnt | output | NUM_MST | One-hot grant |
| gnt_idx | output | $clog2(NUM_MST) | Index of the current owner |
| gnt_held | output | 1 | 1 when the owner won with a request, 0 when the grant is parked |

## Verification
The bench runs the same requests for several strobes in a row. This shows that each rotating pool moves its own pointer: a design with one shared pointer, or with a pointer that does not advance, repeats or skips a winner. Fixed pools get repeated strobes, where a rotating design would move off the lowest index. Mixed pool settings catch a design that orders requesters by index instead of by pool. Strobes with no requests and cycles with the strobe low catch designs that drop the parked owner or change the grant between strobes. A run with every master in pool 3 measures the worst-case wait, and a mid-run reset checks that both pointers return to 0.

// File: rtl/pp_arb_pkg.sv
package pp_arb_pkg;

    typedef enum logic [1:0] {
        POOL_BG   = 2'd0,
        POOL_BW   = 2'd1,
        POOL_LAT  = 2'd2,
        POOL_CRIT = 2'd3
    } pool_e;

    typedef enum logic {
        ST_PARK = 1'b0,
        ST_OWN  = 1'b1
    } arb_st_e;

    localparam int NUM_POOLS = 4;

endpackage

// File: rtl/pp_fix_pick.sv
module pp_fix_pick #(
    parameter int NUM_MST = 4,
    parameter int IDX_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic [NUM_MST-1:0] vec,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    // lowest set index wins; scan from the top so the last write is the lowest
    always_comb begin
        idx = '0;
        for (int i = NUM_MST - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |vec;
    end

endmodule

// File: rtl/pp_rr_pick.sv
module pp_rr_pick #(
    parameter int NUM_MST = 4,
    parameter int IDX_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic [NUM_MST-1:0] vec,
    input  logic [IDX_W-1:0]   ptr,
    output logic [IDX_W-1:0]   idx
);

    logic [NUM_MST-1:0] upper;
    logic [IDX_W-1:0]   up_idx;
    logic [IDX_W-1:0]   all_idx;
    logic               up_any;
    logic               all_any;

    // requesters at or above the pointer
    always_comb begin
        for (int i = 0; i < NUM_MST; i++) begin
            upper[i] = vec[i] && (IDX_W'(i) >= ptr);
        end
    end

    pp_fix_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_up (
        .vec (upper),
        .idx (up_idx),
        .any (up_any)
    );

    pp_fix_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_all (
        .vec (vec),
        .idx (all_idx),
        .any (all_any)
    );

    // if nothing sits at or above the pointer, wrap to the lowest requester
    always_comb begin
        if (up_any) begin
            idx = up_idx;
        end else if (all_any) begin
            idx = all_idx;
        end else begin
            idx = '0;
        end
    end

endmodule

// File: rtl/pp_pool_split.sv
module pp_pool_split
    import pp_arb_pkg::*;
#(
    parameter int NUM_MST = 4
) (
    input  logic [NUM_MST-1:0]          req,
    input  logic [2*NUM_MST-1:0]        prio,
    output logic [NUM_POOLS-1:0][NUM_MST-1:0] pool_req,
    output logic [NUM_POOLS-1:0]        pool_any,
    output pool_e                       top_pool
);

    genvar p, m;
    generate
        for (p = 0; p < NUM_POOLS; p++) begin : g_pool
            for (m = 0; m < NUM_MST; m++) begin : g_mst
                assign pool_req[p][m] = req[m] && (prio[2*m +: 2] == 2'(p));
            end
            assign pool_any[p] = |pool_req[p];
        end
    endgenerate

    // pool level always dominates
    always_comb begin
        if (pool_any[POOL_CRIT]) begin
            top_pool = POOL_CRIT;
        end else if (pool_any[POOL_LAT]) begin
            top_pool = POOL_LAT;
        end else if (pool_any[POOL_BW]) begin
            top_pool = POOL_BW;
        end else begin
            top_pool = POOL_BG;
        end
    end

endmodule

// File: rtl/pp_bus_arbiter.sv
module pp_bus_arbiter
    import pp_arb_pkg::*;
#(
    parameter int NUM_MST = 4,
    localparam int IDX_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arb_en,
    input  logic [NUM_MST-1:0]   req,
    input  logic [2*NUM_MST-1:0] prio,
    output logic [NUM_MST-1:0]   gnt,
    output logic [IDX_W-1:0]     gnt_idx,
    output logic                 gnt_held
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MST - 1);

    logic [NUM_POOLS-1:0][NUM_MST-1:0] pool_req;
    logic [NUM_POOLS-1:0]              pool_any;
    pool_e                             top_pool;
    logic [NUM_POOLS-1:0][IDX_W-1:0]   pool_pick;
    logic [NUM_POOLS-1:0][IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]                  winner;
    logic                              any_req;
    logic                              do_arb;

    arb_st_e                           st_q;
    arb_st_e                           st_d;
    logic [IDX_W-1:0]                  own_q;
    logic [IDX_W-1:0]                  own_d;

    pp_pool_split #(.NUM_MST(NUM_MST)) u_split (
        .req      (req),
        .prio     (prio),
        .pool_req (pool_req),
        .pool_any (pool_any),
        .top_pool (top_pool)
    );

    assign any_req = |pool_any;
    assign do_arb  = arb_en && any_req;

    // outer pools rotate, middle pools use a fixed order
    genvar p;
    generate
        for (p = 0; p < NUM_POOLS; p++) begin : g_pick
            if (p == int'(POOL_CRIT) || p == int'(POOL_BG)) begin : g_rr
                pp_rr_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_rr (
                    .vec (pool_req[p]),
                    .ptr (rr_ptr[p]),
                    .idx (pool_pick[p])
                );

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        rr_ptr[p] <= '0;
                    end else if (do_arb && top_pool == pool_e'(p)) begin
                        rr_ptr[p] <= (pool_pick[p] == LAST_IDX) ? '0
                                                                 : pool_pick[p] + 1'b1;
                    end
                end
            end else begin : g_fix
                logic unused_any;
                pp_fix_pick #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_fix (
                    .vec (pool_req[p]),
                    .idx (pool_pick[p]),
                    .any (unused_any)
                );
                assign rr_ptr[p] = '0;
            end
        end
    endgenerate

    assign winner = pool_pick[top_pool];

    // next-state and next-owner selection
    always_comb begin
        st_d  = st_q;
        own_d = own_q;
        unique case (st_q)
            ST_PARK: begin
                if (do_arb) begin
                    st_d  = ST_OWN;
                    own_d = winner;
                end
            end
            ST_OWN: begin
                if (do_arb) begin
                    own_d = winner;
                end else if (arb_en) begin
                    st_d = ST_PARK;
                end
            end
            default: begin
                st_d = ST_PARK;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_PARK;
            own_q <= '0;
        end else begin
            st_q  <= st_d;
            own_q <= own_d;
        end
    end

    // outputs
    always_comb begin
        gnt          = '0;
        gnt[own_q]   = 1'b1;
        gnt_idx      = own_q;
        gnt_held     = (st_q == ST_OWN);
    end

endmodule

// File: rtl/pp_bus_arbiter_chk.sv
module pp_bus_arbiter_chk #(
    parameter int NUM_MST = 4,
    parameter int IDX_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 arb_en,
    input logic [NUM_MST-1:0]   req,
    input logic [2*NUM_MST-1:0] prio,
    input logic [NUM_MST-1:0]   gnt,
    input logic [IDX_W-1:0]     gnt_idx,
    input logic                 gnt_held
);

    localparam int CNT_W = IDX_W + 2;

    logic [NUM_MST-1:0]   req_q;
    logic [2*NUM_MST-1:0] prio_q;
    logic [1:0]           best_now;
    logic [1:0]           best_q;

    always_comb begin
        best_now = 2'd0;
        for (int m = 0; m < NUM_MST; m++) begin
            if (req[m] && prio[2*m +: 2] > best_now) begin
                best_now = prio[2*m +: 2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= '0;
            prio_q <= '0;
            best_q <= '0;
        end else begin
            req_q  <= req;
            prio_q <= prio;
            best_q <= best_now;
        end
    end

    // R2
    onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt) == 1 && gnt[gnt_idx]);

    // R8
    hold_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |=> $stable(gnt) && $stable(gnt_held));

    // R9
    park_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && req == '0) |=> $stable(gnt_idx) && !gnt_held);

    // R10
    winner_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && req != '0) |=> req_q[gnt_idx] && gnt_held);

    // R3
    pool_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && req != '0) |=> prio_q[2*gnt_idx +: 2] == best_q);

    genvar m;
    generate
        for (m = 0; m < NUM_MST; m++) begin : g_lat
            logic             seen_q;
            logic [CNT_W-1:0] miss_q;
            logic [CNT_W-1:0] miss_d;
            logic             crit_req;

            assign crit_req = req[m] && prio[2*m +: 2] == 2'd3;

            always_comb begin
                miss_d = miss_q;
                if (seen_q) begin
                    miss_d = (gnt_idx == IDX_W'(m)) ? '0 : miss_q + 1'b1;
                end
                if (arb_en && !crit_req) begin
                    miss_d = '0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    seen_q <= 1'b0;
                    miss_q <= '0;
                end else begin
                    seen_q <= arb_en && crit_req;
                    miss_q <= miss_d;
                end
            end

            // R7
            crit_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
                miss_q <= CNT_W'(NUM_MST - 1));
        end
    endgenerate

endmodule

bind pp_bus_arbiter pp_bus_arbiter_chk #(.NUM_MST(NUM_MST)) u_pp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arb_en   (arb_en),
    .req      (req),
    .prio     (prio),
    .gnt      (gnt),
    .gnt_idx  (gnt_idx),
    .gnt_held (gnt_held)
);

// File: tb/test_pp_bus_arbiter.sv
module test_pp_bus_arbiter;

    localparam int N  = 4;
    localparam int IW = 2;
    // {tag[3:0], en, req[3:0], prio[7:0], exp_idx[1:0]}
    localparam int VW = 19;
    localparam int NV = 21;

    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd9,  1'b1, 4'b0000, 8'h00, 2'd0}, // R9 park after reset
        {4'd5,  1'b1, 4'b1111, 8'h00, 2'd0}, // R5 pool0 rotates
        {4'd5,  1'b1, 4'b1111, 8'h00, 2'd1},
        {4'd5,  1'b1, 4'b1111, 8'h00, 2'd2},
        {4'd5,  1'b1, 4'b1111, 8'h00, 2'd3},
        {4'd5,  1'b1, 4'b1111, 8'h00, 2'd0}, // R5 wrap
        {4'd8,  1'b0, 4'b1111, 8'h00, 2'd0}, // R8 strobe low
        {4'd9,  1'b1, 4'b0000, 8'h00, 2'd0}, // R9 park
        {4'd3,  1'b1, 4'b1111, 8'h10, 2'd2}, // R3 pool1 beats pool0
        {4'd6,  1'b1, 4'b1111, 8'h88, 2'd1}, // R6 lowest in pool2
        {4'd6,  1'b1, 4'b1111, 8'h88, 2'd1}, // R6 no rotation
        {4'd6,  1'b1, 4'b1000, 8'h88, 2'd3},
        {4'd4,  1'b1, 4'b1111, 8'hBB, 2'd0}, // R4 pool3 rotates
        {4'd4,  1'b1, 4'b1111, 8'hBB, 2'd2},
        {4'd4,  1'b1, 4'b1111, 8'hBB, 2'd0}, // R4 wrap
        {4'd5,  1'b1, 4'b1111, 8'h00, 2'd1}, // R5 own pointer kept
        {4'd5,  1'b1, 4'b0001, 8'h00, 2'd0},
        {4'd5,  1'b1, 4'b1100, 8'h00, 2'd2},
        {4'd4,  1'b1, 4'b1111, 8'hFF, 2'd1}, // R4 pointer kept at 1
        {4'd3,  1'b1, 4'b1001, 8'h40, 2'd3}, // R3 pool1 over pool0
        {4'd8,  1'b0, 4'b0001, 8'h00, 2'd3}  // R8 hold
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arb_en = 1'b0;
    logic [N-1:0] req = '0;
    logic [2*N-1:0] prio = '0;
    logic [N-1:0] gnt;
    logic [IW-1:0] gnt_idx;
    logic         gnt_held;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pp_bus_arbiter #(.NUM_MST(N)) i_pp_bus_arbiter (
        .clk      (clk),
        .rst_n    (rst_n),
        .arb_en   (arb_en),
        .req      (req),
        .prio     (prio),
        .gnt      (gnt),
        .gnt_idx  (gnt_idx),
        .gnt_held (gnt_held)
    );

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // apply at negedge, result registered at posedge, sample at next negedge
    task automatic step(input logic en, input logic [N-1:0] r, input logic [2*N-1:0] p);
        arb_en = en;
        req    = r;
        prio   = p;
        @(negedge clk);
    endtask

    initial begin
        logic held_exp;
        int   losses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 idx", int'(gnt_idx), 0);
        check("R1 gnt", int'(gnt), 1);
        check("R1 held", int'(gnt_held), 0);

        held_exp = 1'b0;
        for (int i = 0; i < NV; i++) begin
            logic [3:0] tg;
            logic       en;
            logic [N-1:0] r;
            logic [2*N-1:0] p;
            logic [IW-1:0] e;
            {tg, en, r, p, e} = VEC[i];
            step(en, r, p);
            if (en) held_exp = (r != '0);
            total++;
            if (gnt_idx != e) begin
                bad++;
                $display("FAIL R%0d vec %0d idx got=%0d exp=%0d", tg, i, gnt_idx, e);
            end
            check("R2 onehot", int'(gnt), 1 << e);
            check("R9 held", int'(gnt_held), int'(held_exp));
        end

        // R8 several idle cycles with changing requests
        step(1'b0, 4'b0110, 8'hFF);
        step(1'b0, 4'b0001, 8'h00);
        check("R8 hold idx", int'(gnt_idx), 3);

        // R10 result visible right after the sampling edge
        arb_en = 1'b1; req = 4'b0100; prio = 8'h00;
        @(posedge clk);
        #1;
        check("R10 same edge", int'(gnt_idx), 2);
        @(negedge clk);

        // R1 mid-run reset clears pointers
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset idx", int'(gnt_idx), 0);
        rst_n = 1'b1;
        step(1'b1, 4'b1111, 8'h00);
        step(1'b1, 4'b1111, 8'h00);
        check("R5 pointer reset", int'(gnt_idx), 1);

        // R7 all in pool3, master 3 waits at most N-1 strobes
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        losses = 0;
        for (int k = 0; k < N; k++) begin
            step(1'b1, 4'b1111, 8'hFF);
            if (gnt_idx == 2'd3) break;
            losses++;
        end
        check("R7 losses", losses, N - 1);

        // R6 pool1 fixed order, lowest index repeatedly
        step(1'b1, 4'b1110, 8'h54);
        step(1'b1, 4'b1110, 8'h54);
        check("R6 pool1 fixed", int'(gnt_idx), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule